// File: doc/BRIEF.md
# Cascadable Programmable Tap Delay Controller

This block is a clocked model of a digitally programmed delay element. A one-bit serial input is delayed by a selectable number of clock cycles. Each cycle stands for a quarter of a base stage. A seven-bit tap code and a separate cascade bit are captured in a control latch. The latch is open while the hold input is low and keeps its contents while the hold input is high. Two override inputs force the shortest setting or the longest setting. An input block stops new input values from entering the delay line.

Two instances chain with no extra logic. The first instance's cascade output drives its own force-max input, and its inverted cascade output drives the second instance's force-min input. The shared tap bus then addresses whichever stage is active. The total delay rises by one unit for each step of the combined eight-bit code, including the step where control passes from the first instance to the second.

Top module: `tapdly_top`

## Requirements
- R1: After a synchronous reset, `dataOut` and `cascadeOut` are 0, `cascadeOutN` is 1, and the selected tap is 0.
- R2: While `latchHold` is low, `tapCode` and `cascadeIn` are captured at each clock edge, so a new code takes effect without any further strobe.
- R3: While `latchHold` is high and no override is asserted, changes on `tapCode` and `cascadeIn` do not change the delay or `cascadeOut`.
- R4: Tap bit i adds 2^i quarter-stage units. A rising edge sampled on `dataIn` at clock edge 0 appears on `dataOut` after edge 2 + code.
- R5: `forceMin` clears all eight latch bits, whatever `latchHold` and the bus are doing. The delay becomes 2 cycles and `cascadeOut` becomes 0.
- R6: `forceMax` sets tap bits 0 and 1 to 0 and bits 2 to 6 to 1, and adds one extra stage (4 units). The delay is 2 + 128 cycles. The cascade bit is not changed by this override.
- R7: When `forceMin` and `forceMax` are both high, `forceMin` wins and the delay is 2 cycles.
- R8: `cascadeOut` equals the latched cascade bit, and `cascadeOutN` is its complement.
- R9: While `blockIn` is high, no transition on `dataIn` reaches `dataOut`.
- R10: When two instances are chained, a combined code C (cascade bit as bit 7) gives a total delay of 5 + C cycles for C < 128 and 5 + 128 + (C − 128) cycles otherwise. The delay is strictly increasing over all 256 codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tapCode | input | 7 | Tap code bus |
| cascadeIn | input | 1 | Cascade control bit |
| latchHold | input | 1 | High holds the control latch, low lets it follow the bus |
| forceMin | input | 1 | Force minimum delay (highest priority) |
| forceMax | input | 1 | Force maximum delay |
| blockIn | input | 1 | Stops `dataIn` from entering the delay line |
| dataIn | input | 1 | Serial data input |
| dataOut | output | 1 | Delayed data output |
| cascadeOut | output | 1 | Latched cascade bit |
| cascadeOutN | output | 1 | Complement of `cascadeOut` |

## Verification
Control changes are registered once, so a new code, override or cascade bit applies from the next edge. The bench allows three edges for settling before it sends a single-cycle pulse. The pulse counts as edge 0. An output high after edge 2 + code for one instance, or after edge 5 + combined code for the chain, is observed at the falling edge that follows. The bench counts falling edges until the first high output and compares that count with the arithmetic expectation. Its 400-cycle window flushes every earlier pulse from both delay lines before the next measurement starts.

// File: rtl/tapdly_pkg.sv
package tapdly_pkg;
  localparam int TAP_W         = 7;                  // tap code bits
  localparam int UNITS_PER_STG = 4;                  // clock units per base stage
  localparam int MAX_SEL       = 1 << TAP_W;         // tap under force-max
  localparam int LINE_DEPTH    = MAX_SEL + 1;        // delay line stages
  localparam int SEL_W         = $clog2(LINE_DEPTH);
  localparam int LOW_FORCED    = $clog2(UNITS_PER_STG); // bits cleared by force-max

  typedef struct packed {
    logic [SEL_W-1:0] tapSel;    // selected tap of the delay line
    logic             holdInput; // freeze the input register
  } pathCtrl_t;
endpackage

// File: rtl/tapdly_ctrl.sv
module tapdly_ctrl
  import tapdly_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [TAP_W-1:0] tapCode,
  input  logic             cascadeIn,
  input  logic             latchHold,
  input  logic             forceMin,
  input  logic             forceMax,
  input  logic             blockIn,
  output pathCtrl_t        ctrl,
  output logic             cascadeOut,
  output logic             cascadeOutN
);
  localparam logic [TAP_W-1:0] MAX_PATTERN =
    TAP_W'((MAX_SEL - UNITS_PER_STG) & ((1 << TAP_W) - 1));

  logic [TAP_W-1:0] tapLatch;
  logic             casLatch;
  logic             maxHeld;

  // tap bits: min beats max beats load beats hold
  always_ff @(posedge clk) begin
    if (rst || forceMin) begin
      tapLatch <= '0;
      maxHeld  <= 1'b0;
    end else if (forceMax) begin
      tapLatch <= MAX_PATTERN;
      maxHeld  <= 1'b1;
    end else begin
      maxHeld <= 1'b0;
      if (!latchHold) tapLatch <= tapCode;
    end
  end

  // cascade bit: cleared by min, untouched by max
  always_ff @(posedge clk) begin
    if (rst || forceMin)  casLatch <= 1'b0;
    else if (!latchHold)  casLatch <= cascadeIn;
  end

  always_comb begin
    ctrl.tapSel    = SEL_W'(tapLatch) + (maxHeld ? SEL_W'(UNITS_PER_STG) : '0);
    ctrl.holdInput = blockIn;
  end

  assign cascadeOut  = casLatch;
  assign cascadeOutN = ~casLatch;

  assert_min_clears_R5: assert property (@(posedge clk) disable iff (rst)
    forceMin |=> (ctrl.tapSel == '0 && !cascadeOut));
  assert_min_priority_R7: assert property (@(posedge clk) disable iff (rst)
    (forceMin && forceMax) |=> ctrl.tapSel == '0);
  assert_max_tap_R6: assert property (@(posedge clk) disable iff (rst)
    (forceMax && !forceMin) |=> ctrl.tapSel == SEL_W'(MAX_SEL));
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (latchHold && !forceMin && !forceMax && !$past(forceMax))
      |=> ($stable(ctrl.tapSel) && $stable(cascadeOut)));
endmodule

// File: rtl/tapdly_path.sv
module tapdly_path
  import tapdly_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pathCtrl_t ctrl,
  input  logic      dataIn,
  output logic      dataOut
);
  logic                  inReg;
  logic [LINE_DEPTH-1:0] line;
  logic                  outReg;

  always_ff @(posedge clk) begin
    if (rst)                  inReg <= 1'b0;
    else if (!ctrl.holdInput) inReg <= dataIn;
  end

  genvar g;
  generate
    for (g = 0; g < LINE_DEPTH; g++) begin : gStage
      always_ff @(posedge clk) begin
        if (rst)         line[g] <= 1'b0;
        else if (g == 0) line[g] <= inReg;
        else             line[g] <= line[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) outReg <= 1'b0;
    else     outReg <= line[ctrl.tapSel];
  end

  assign dataOut = outReg;

  assert_block_freezes_R9: assert property (@(posedge clk) disable iff (rst)
    ctrl.holdInput |=> $stable(inReg));
  assert_tap_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl.tapSel <= SEL_W'(MAX_SEL));
endmodule

// File: rtl/tapdly_top.sv
module tapdly_top
  import tapdly_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [TAP_W-1:0] tapCode,
  input  logic             cascadeIn,
  input  logic             latchHold,
  input  logic             forceMin,
  input  logic             forceMax,
  input  logic             blockIn,
  input  logic             dataIn,
  output logic             dataOut,
  output logic             cascadeOut,
  output logic             cascadeOutN
);
  pathCtrl_t ctrl;

  tapdly_ctrl uCtrl (
    .clk(clk), .rst(rst), .tapCode(tapCode), .cascadeIn(cascadeIn),
    .latchHold(latchHold), .forceMin(forceMin), .forceMax(forceMax),
    .blockIn(blockIn), .ctrl(ctrl), .cascadeOut(cascadeOut),
    .cascadeOutN(cascadeOutN)
  );

  tapdly_path uPath (
    .clk(clk), .rst(rst), .ctrl(ctrl), .dataIn(dataIn), .dataOut(dataOut)
  );

  assert_cascade_pair_R8: assert property (@(posedge clk) disable iff (rst)
    cascadeOut != cascadeOutN);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!dataOut && !cascadeOut && cascadeOutN));
endmodule

// File: tb/tb_tapdly_top.sv
module tb_tapdly_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] code = '0;
  logic casBit = 1'b0, hold = 1'b1, din = 1'b0;
  logic cBit = 1'b0, fmC = 1'b0, fxC = 1'b0, blkC = 1'b0;
  logic qA, casA, casAN, qB, casB, casBN, qC, casC, casCN;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  // chain head
  tapdly_top dut (.clk(clk), .rst(rst), .tapCode(code), .cascadeIn(casBit),
    .latchHold(hold), .forceMin(1'b0), .forceMax(casA), .blockIn(1'b0),
    .dataIn(din), .dataOut(qA), .cascadeOut(casA), .cascadeOutN(casAN));
  // chain tail
  tapdly_top dutTail (.clk(clk), .rst(rst), .tapCode(code), .cascadeIn(1'b0),
    .latchHold(hold), .forceMin(casAN), .forceMax(1'b0), .blockIn(1'b0),
    .dataIn(qA), .dataOut(qB), .cascadeOut(casB), .cascadeOutN(casBN));
  // standalone instance for override tests
  tapdly_top dutSolo (.clk(clk), .rst(rst), .tapCode(code), .cascadeIn(cBit),
    .latchHold(hold), .forceMin(fmC), .forceMax(fxC), .blockIn(blkC),
    .dataIn(din), .dataOut(qC), .cascadeOut(casC), .cascadeOutN(casCN));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // one-cycle pulse sampled at edge 0; latency = first edge after which output is high
  task automatic measure(output int latB, output int latC);
    latB = -1; latC = -1;
    @(negedge clk) din = 1'b1;
    @(negedge clk) din = 1'b0;
    for (int k = 1; k < 400; k++) begin
      @(negedge clk);
      if (qB && latB < 0) latB = k;
      if (qC && latC < 0) latC = k;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lb, lc, prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 dataOut", qC, 0);
    chk("R1 cascadeOut", casC, 0);
    chk("R1 cascadeOutN", casCN, 1);
    chk("R1 head cascadeOutN", casAN, 1);

    // R10/R4/R2/R8: full sweep of combined codes
    prev = -1;
    for (int c = 0; c < 256; c++) begin
      hold = 1'b0; code = 7'(c); casBit = c[7]; cBit = c[7];
      settle();
      measure(lb, lc);
      chk($sformatf("R10 chain code %0d", c), lb,
          (c < 128) ? 5 + c : 5 + 128 + (c - 128));
      if (lb <= prev) chk("R10 monotonic", lb, prev + 1);
      prev = lb;
      chk($sformatf("R4 R2 solo code %0d", c), lc, 2 + (c % 128));
      chk("R8 cascadeOut", casC, c[7]);
      chk("R8 cascadeOutN", casCN, !c[7]);
    end

    // R3: hold keeps code 10 while bus changes
    code = 7'd10; cBit = 1'b0; settle();
    hold = 1'b1; code = 7'd100; cBit = 1'b1; settle();
    measure(lb, lc);
    chk("R3 held delay", lc, 12);
    chk("R3 held cascade", casC, 0);

    // R5: force-min with open latch and busy bus
    hold = 1'b0; code = 7'd50; cBit = 1'b1; fmC = 1'b1; settle();
    measure(lb, lc);
    chk("R5 min delay", lc, 2);
    chk("R5 min cascade", casC, 0);
    hold = 1'b1; fmC = 1'b0; settle();
    measure(lb, lc);
    chk("R5 cleared latch held", lc, 2);

    // R7: both overrides
    fmC = 1'b1; fxC = 1'b1; settle();
    measure(lb, lc);
    chk("R7 min priority", lc, 2);

    // R6: force-max, cascade bit untouched
    fmC = 1'b0; settle();
    measure(lb, lc);
    chk("R6 max delay", lc, 130);
    chk("R6 cascade unchanged", casC, 0);
    fxC = 1'b0; settle();

    // R9: blocked input
    hold = 1'b0; code = 7'd3; settle();
    blkC = 1'b1;
    measure(lb, lc);
    chk("R9 blocked pulse", lc, -1);
    blkC = 1'b0; settle();
    measure(lb, lc);
    chk("R9 unblocked pulse", lc, 5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule